// File: doc/BRIEF.md
# Ethernet Transmit Frame FIFO

This block collects a frame that a host hands over as 32-bit words and releases it as a byte stream once it is ready to go. The host writes words into a 2048-byte buffer. The first word written into an empty buffer is a header word: its low 16 bits give the payload length, which does not count the 14-byte Ethernet header. The remaining words carry the header and the payload, least significant byte first. The outgoing stream starts two bytes into the buffer, so the length field itself is never sent.

A frame leaves in one of two ways. The first is automatic: after a data word is stored, the block checks two tests, and sends when both pass. The buffer must hold at least the fill level set by a programmable threshold, and it must hold the whole frame. The second is a send request from software, which forces the frame out at once. Short frames can be padded with zeros up to the 60-byte Ethernet minimum. When a header word carries a length that is too large, the block raises an error flag. When a send finishes, it raises an empty flag.

The byte stream uses a valid/ready handshake with a last-byte marker. A one-cycle start pulse, together with the frame length, opens each frame, and a one-cycle done pulse closes it. While a frame is going out, the host write port stalls. MAC framing, preamble, CRC insertion and the PHY are handled elsewhere.

Top module: `eth_tx_frame_fifo`

## Requirements
- R1: When the buffer is empty, a word whose low 16 bits exceed 2032 is discarded: nothing is stored, nothing is sent, and `err_flag` is set.
- R2: An accepted word occupies the next 4 buffer bytes, with bits 7:0 in the lowest byte. A word is stored only while at least 4 of the 2048 bytes are free; a word written to a full buffer changes nothing.
- R3: A frame counts as complete when the stored byte count is at least payload+16, or payload+20 when `cfg_auto_crc` is 0, with the requirement capped at 2048.
- R4: Threshold setting T (6 bits, written through `thr_we`/`thr_wdata`, reset value 63) is active only when T < 63, and is reached when the stored byte count is at least 4*(8*T+1). At reset no data write can start a send.
- R5: After each stored data word, a send starts on the same clock edge when the threshold is active and reached and the frame is complete; otherwise no send starts.
- R6: A `send_req` pulse while idle starts a send on that edge, whatever the fill level.
- R7: The frame length is payload+14 capped at 2046. Byte i of the stream is buffer byte i+2. When `cfg_pad` is 1 and the length is below 60, the stream is extended with zero bytes to 60, and `tx_len` reports the final length.
- R8: After the last byte is accepted, the byte count returns to zero, `empty_flag` is set and `tx_done` pulses for one cycle. `empty_ack` clears `empty_flag`.
- R9: An `err_ack` pulse clears `err_flag` and, while idle, empties the buffer, so the next word written counts as a header word.
- R10: `wr_ready` is low for every cycle that `tx_valid` is high. `tx_start` pulses on the first cycle of each frame.
- R11: When a data write and `send_req` occur on the same edge, the word is stored first, and the frame sent includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host word valid |
| wr_data | input | 32 | Host word |
| wr_ready | output | 1 | Host word accepted (low while sending) |
| thr_we | input | 1 | Load threshold setting |
| thr_wdata | input | 6 | New threshold setting |
| cfg_pad | input | 1 | Pad short frames to 60 bytes |
| cfg_auto_crc | input | 1 | CRC is generated downstream (frame needs no CRC bytes) |
| send_req | input | 1 | Force a send |
| err_ack | input | 1 | Clear error flag and empty the buffer |
| empty_ack | input | 1 | Clear empty flag |
| err_flag | output | 1 | Oversize length rejected |
| empty_flag | output | 1 | A send has finished |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_start | output | 1 | First cycle of a frame |
| tx_len | output | 12 | Length of the frame being sent |
| tx_done | output | 1 | Frame finished (one cycle) |

## Verification
The overlap that matters is a host data write landing on the same edge as a software send request. The word must be stored before the send is decided, so that it appears in the outgoing bytes. The bench provokes this with a directed case: it pre-loads a partial frame with the threshold disabled, then drives `wr_valid` and `send_req` together. It then compares the streamed bytes with its own buffer mirror, where the new word must show up at stream bytes 10 to 13. An error acknowledge followed at once by a new header word is also driven, and judged by whether the next frame uses the new length.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic {
        TXF_IDLE = 1'b0,
        TXF_SEND = 1'b1
    } txf_state_e;
endpackage

// File: rtl/txf_store.sv
// Word-wide buffer: synchronous write, combinational read.
module txf_store #(
    parameter int WORDS = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/txf_gate.sv
// Decides whether the fill level passes both the threshold and completeness tests.
module txf_gate #(
    parameter int CW        = 12,
    parameter int THR_W     = 6,
    parameter int BUF_BYTES = 2048
) (
    input  logic [CW-1:0]    fill,
    input  logic [15:0]      payload,
    input  logic [THR_W-1:0] thr,
    input  logic             auto_crc,
    output logic             fire
);
    localparam int NW = 18;

    logic [NW-1:0] need_raw;
    logic [NW-1:0] need;
    logic [NW-1:0] lvl;
    logic          thr_on;

    always_comb begin
        need_raw = NW'(payload) + NW'(16) + (auto_crc ? NW'(0) : NW'(4));
        need     = (need_raw > NW'(BUF_BYTES)) ? NW'(BUF_BYTES) : need_raw;
        lvl      = (NW'(thr) << 5) + NW'(4);
        thr_on   = (thr != {THR_W{1'b1}});
        fire     = thr_on && (NW'(fill) >= lvl) && (NW'(fill) >= need);
    end
endmodule

// File: rtl/txf_sizer.sv
// Frame length from payload length: header added, capped, optionally padded.
module txf_sizer #(
    parameter int CW        = 12,
    parameter int HDR_BYTES = 14,
    parameter int MIN_FRAME = 60,
    parameter int TX_CAP    = 2046
) (
    input  logic [15:0]   payload,
    input  logic          pad,
    output logic [CW-1:0] data_len,
    output logic [CW-1:0] frame_len
);
    logic [16:0] raw;
    logic [16:0] capped;

    always_comb begin
        raw       = 17'(payload) + 17'(HDR_BYTES);
        capped    = (raw > 17'(TX_CAP)) ? 17'(TX_CAP) : raw;
        data_len  = CW'(capped);
        frame_len = (pad && (capped < 17'(MIN_FRAME))) ? CW'(MIN_FRAME) : CW'(capped);
    end
endmodule

// File: rtl/eth_tx_frame_fifo.sv
module eth_tx_frame_fifo #(
    parameter int BUF_BYTES   = 2048,
    parameter int MAX_PAYLOAD = 2032,
    parameter int HDR_BYTES   = 14,
    parameter int MIN_FRAME   = 60,
    parameter int THR_W       = 6,
    parameter int CW          = $clog2(BUF_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    output logic             wr_ready,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             cfg_pad,
    input  logic             cfg_auto_crc,
    input  logic             send_req,
    input  logic             err_ack,
    input  logic             empty_ack,
    output logic             err_flag,
    output logic             empty_flag,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             tx_ready,
    output logic             tx_start,
    output logic [CW-1:0]    tx_len,
    output logic             tx_done
);
    import txf_pkg::*;

    localparam int WORDS  = BUF_BYTES / 4;
    localparam int AW     = $clog2(WORDS);
    localparam int TX_CAP = BUF_BYTES - 2;

    typedef struct packed {
        txf_state_e       st;
        logic [CW-1:0]    cnt;
        logic [15:0]      plen;
        logic [THR_W-1:0] thr;
        logic             err;
        logic             emp;
        logic [CW-1:0]    idx;
        logic [CW-1:0]    flen;
        logic [CW-1:0]    dlen;
        logic             start;
        logic             done;
    } regs_t;

    regs_t q, d;

    logic          idle;
    logic          wr_fire;
    logic [CW-1:0] cnt_base;
    logic          first_word;
    logic          len_bad;
    logic          store;
    logic [CW-1:0] cnt_new;
    logic [15:0]   plen_eff;
    logic          gate_fire;
    logic          go;
    logic [CW-1:0] sz_dlen;
    logic [CW-1:0] sz_flen;
    logic [CW-1:0] rd_pos;
    logic [31:0]   rd_word;
    logic [7:0]    rd_byte;

    txf_store #(.WORDS(WORDS), .AW(AW)) u_store (
        .clk   (clk),
        .we    (store),
        .waddr (cnt_base[AW+1:2]),
        .wdata (wr_data),
        .raddr (rd_pos[AW+1:2]),
        .rdata (rd_word)
    );

    txf_gate #(.CW(CW), .THR_W(THR_W), .BUF_BYTES(BUF_BYTES)) u_gate (
        .fill     (cnt_new),
        .payload  (plen_eff),
        .thr      (q.thr),
        .auto_crc (cfg_auto_crc),
        .fire     (gate_fire)
    );

    txf_sizer #(.CW(CW), .HDR_BYTES(HDR_BYTES), .MIN_FRAME(MIN_FRAME), .TX_CAP(TX_CAP)) u_sizer (
        .payload   (plen_eff),
        .pad       (cfg_pad),
        .data_len  (sz_dlen),
        .frame_len (sz_flen)
    );

    // Read side: stream byte i sits at buffer offset i+2.
    always_comb begin
        rd_pos = q.idx + CW'(2);
        case (rd_pos[1:0])
            2'd0:    rd_byte = rd_word[7:0];
            2'd1:    rd_byte = rd_word[15:8];
            2'd2:    rd_byte = rd_word[23:16];
            default: rd_byte = rd_word[31:24];
        endcase
    end

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.done  = 1'b0;

        idle       = (q.st == TXF_IDLE);
        wr_fire    = wr_valid && idle;
        cnt_base   = (err_ack && idle) ? '0 : q.cnt;
        first_word = (cnt_base == '0);
        len_bad    = wr_fire && first_word && (wr_data[15:0] > 16'(MAX_PAYLOAD));
        store      = wr_fire && !len_bad && (cnt_base <= CW'(BUF_BYTES - 4));
        cnt_new    = store ? cnt_base + CW'(4) : cnt_base;
        plen_eff   = (store && first_word) ? wr_data[15:0] : q.plen;
        go         = idle && ((wr_fire && !len_bad && gate_fire) || send_req);

        if (thr_we) begin
            d.thr = thr_wdata;
        end
        if (err_ack) begin
            d.err = 1'b0;
        end
        if (len_bad) begin
            d.err = 1'b1;
        end
        if (empty_ack) begin
            d.emp = 1'b0;
        end

        if (idle) begin
            d.cnt  = cnt_new;
            d.plen = plen_eff;
            if (go) begin
                d.st    = TXF_SEND;
                d.idx   = '0;
                d.flen  = sz_flen;
                d.dlen  = sz_dlen;
                d.start = 1'b1;
            end
        end else if (tx_ready) begin
            if (q.idx == q.flen - CW'(1)) begin
                d.st   = TXF_IDLE;
                d.cnt  = '0;
                d.emp  = 1'b1;
                d.done = 1'b1;
            end else begin
                d.idx = q.idx + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= TXF_IDLE;
            q.cnt   <= '0;
            q.plen  <= '0;
            q.thr   <= {THR_W{1'b1}};
            q.err   <= 1'b0;
            q.emp   <= 1'b0;
            q.idx   <= '0;
            q.flen  <= '0;
            q.dlen  <= '0;
            q.start <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign wr_ready   = (q.st == TXF_IDLE);
    assign err_flag   = q.err;
    assign empty_flag = q.emp;
    assign tx_valid   = (q.st == TXF_SEND);
    assign tx_data    = (q.idx < q.dlen) ? rd_byte : 8'h00;
    assign tx_last    = tx_valid && (q.idx == q.flen - CW'(1));
    assign tx_start   = q.start;
    assign tx_len     = q.flen;
    assign tx_done    = q.done;
endmodule

// File: rtl/txf_chk.sv
module txf_chk #(
    parameter int CW        = 12,
    parameter int HDR_BYTES = 14,
    parameter int TX_CAP    = 2046
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          err_ack,
    input logic          err_flag,
    input logic          empty_flag,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          tx_last,
    input logic          tx_start,
    input logic [7:0]    tx_data,
    input logic [CW-1:0] tx_len,
    input logic          tx_done
);
    AST_STALL_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !wr_ready) else $error("stall"); // R10
    AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tx_valid) else $error("start"); // R10
    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_len <= CW'(TX_CAP)) && (tx_len >= CW'(HDR_BYTES))) else $error("len"); // R7
    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_len)) else $error("hold"); // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> tx_done && !tx_valid && empty_flag) else $error("done"); // R8
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ack && !wr_valid) |=> !err_flag) else $error("errclr"); // R9
endmodule

bind eth_tx_frame_fifo txf_chk #(.CW(CW), .HDR_BYTES(HDR_BYTES), .TX_CAP(BUF_BYTES - 2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .err_ack    (err_ack),
    .err_flag   (err_flag),
    .empty_flag (empty_flag),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_last    (tx_last),
    .tx_start   (tx_start),
    .tx_data    (tx_data),
    .tx_len     (tx_len),
    .tx_done    (tx_done)
);

// File: tb/eth_tx_frame_fifo_tb.sv
module eth_tx_frame_fifo_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        thr_we = 1'b0;
    logic [5:0]  thr_wdata = '0;
    logic        cfg_pad = 1'b0;
    logic        cfg_auto_crc = 1'b1;
    logic        send_req = 1'b0;
    logic        err_ack = 1'b0;
    logic        empty_ack = 1'b0;
    logic        err_flag;
    logic        empty_flag;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b0;
    logic        tx_start;
    logic [11:0] tx_len;
    logic        tx_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eth_tx_frame_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .cfg_pad(cfg_pad), .cfg_auto_crc(cfg_auto_crc),
        .send_req(send_req), .err_ack(err_ack), .empty_ack(empty_ack), .err_flag(err_flag),
        .empty_flag(empty_flag), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_start(tx_start), .tx_len(tx_len), .tx_done(tx_done)
    );

    int nchk = 0;
    int nbad = 0;
    logic [7:0] mbuf [2048];
    int mcnt = 0;
    int mplen = 0;
    int mthr = 63;
    bit sent;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_fire();
        int need;
        need = mplen + 16 + (cfg_auto_crc ? 0 : 4);
        if (need > 2048) need = 2048;
        return (mthr < 63) && (mcnt >= 4 * (mthr * 8 + 1)) && (mcnt >= need);
    endfunction

    task automatic recv_frame();
        int raw, flen, idx, guard;
        raw = mplen + 14;
        if (raw > 2046) raw = 2046;
        flen = (cfg_pad && raw < 60) ? 60 : raw;
        chk(tx_valid == 1'b1, "R5 R6 send started", int'(tx_valid), 1);
        chk(tx_start == 1'b1, "R10 start pulse", int'(tx_start), 1);
        chk(int'(tx_len) == flen, "R7 frame length", int'(tx_len), flen);
        idx = 0;
        guard = 0;
        while (idx < flen && guard < 20000) begin
            guard++;
            tx_ready = (($urandom % 4) != 0);
            if (tx_valid !== 1'b1 || wr_ready !== 1'b0) begin
                chk(1'b0, "R10 valid high and write stalled", int'(wr_ready), 0);
            end
            if (tx_ready) begin
                chk(tx_data == ((idx < raw) ? mbuf[idx + 2] : 8'h00), "R7 stream byte",
                    int'(tx_data), int'((idx < raw) ? mbuf[idx + 2] : 8'h00));
                chk(tx_last == (idx == flen - 1), "R7 last marker", int'(tx_last), int'(idx == flen - 1));
                idx++;
            end
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk(tx_done == 1'b1, "R8 done pulse", int'(tx_done), 1);
        chk(empty_flag == 1'b1, "R8 empty flag", int'(empty_flag), 1);
        chk(tx_valid == 1'b0 && wr_ready == 1'b1, "R10 idle after frame", int'(wr_ready), 1);
        mcnt = 0;
    endtask

    task automatic do_write(input logic [31:0] w, input bit with_req, output bit fired);
        bit bad;
        @(negedge clk);
        chk(wr_ready == 1'b1, "R10 ready while idle", int'(wr_ready), 1);
        wr_valid = 1'b1;
        wr_data = w;
        send_req = with_req;
        @(negedge clk);
        wr_valid = 1'b0;
        send_req = 1'b0;
        bad = (mcnt == 0) && (w[15:0] > 16'd2032);
        fired = with_req;
        if (!bad) begin
            if (mcnt <= 2044) begin
                for (int b = 0; b < 4; b++) mbuf[mcnt + b] = w[8*b +: 8];
                if (mcnt == 0) mplen = int'(w[15:0]);
                mcnt += 4;
            end
            if (model_fire()) fired = 1'b1;
        end
        if (fired) recv_frame();
        else chk(tx_valid == 1'b0, "R4 R5 no send yet", int'(tx_valid), 0);
    endtask

    task automatic force_send();
        @(negedge clk);
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
        recv_frame();
    endtask

    task automatic set_thr(input int v);
        @(negedge clk);
        thr_we = 1'b1;
        thr_wdata = 6'(v);
        @(negedge clk);
        thr_we = 1'b0;
        mthr = v;
    endtask

    task automatic ack_err();
        @(negedge clk);
        err_ack = 1'b1;
        @(negedge clk);
        err_ack = 1'b0;
        mcnt = 0;
        chk(err_flag == 1'b0, "R9 error cleared", int'(err_flag), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int unsigned seed0;
        int need, pl;
        logic [31:0] w;
        seed0 = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R10 reset valid", int'(tx_valid), 0);
        chk(wr_ready == 1'b1, "R10 reset ready", int'(wr_ready), 1);
        chk(err_flag == 1'b0, "R1 reset err", int'(err_flag), 0);
        chk(empty_flag == 1'b0, "R8 reset empty", int'(empty_flag), 0);

        // R4 R2: full buffer at reset threshold never auto-sends; overflow word is dropped
        cfg_pad = 1'b0;
        cfg_auto_crc = 1'b1;
        do_write(32'hA5A5_07F0, 1'b0, sent);
        for (int i = 1; i < 512; i++) do_write($urandom, 1'b0, sent);
        do_write(32'hFFFF_FFFF, 1'b0, sent);
        force_send(); // R6 R7 max frame of 2046 bytes

        // R8: empty flag clears on acknowledge
        @(negedge clk);
        empty_ack = 1'b1;
        @(negedge clk);
        empty_ack = 1'b0;
        chk(empty_flag == 1'b0, "R8 empty cleared", int'(empty_flag), 1'b0);

        // R1: oversize header word rejected
        set_thr(0);
        do_write(32'h0000_07F1, 1'b0, sent);
        chk(err_flag == 1'b1, "R1 error raised", int'(err_flag), 1);
        do_write(32'h1234_0BB8, 1'b0, sent);
        chk(err_flag == 1'b1, "R1 error held", int'(err_flag), 1);
        ack_err();

        // R9: acknowledge empties a partial frame; R7 padding of a short frame
        cfg_pad = 1'b1;
        do_write(32'h0000_0028, 1'b0, sent);
        for (int i = 0; i < 3; i++) do_write($urandom, 1'b0, sent);
        ack_err();
        do_write(32'h0000_0008, 1'b0, sent);
        for (int i = 0; i < 5; i++) do_write($urandom, 1'b0, sent);
        chk(sent == 1'b1, "R9 R3 new header after ack", int'(sent), 1);

        // R4 boundary: T=1 needs 36 bytes even though frame is complete at 16
        set_thr(1);
        cfg_pad = 1'b0;
        for (int i = 0; i < 9; i++) do_write((i == 0) ? 32'h0 : $urandom, 1'b0, sent);
        chk(sent == 1'b1, "R4 threshold 36 bytes", int'(sent), 1);

        // R11: data write and send request on the same edge
        set_thr(63);
        do_write(32'h0000_0014, 1'b0, sent);
        do_write(32'h0102_0304, 1'b0, sent);
        do_write(32'h0506_0708, 1'b0, sent);
        do_write(32'hDEAD_BEEF, 1'b1, sent);
        chk(sent == 1'b1, "R11 joint write and request", int'(sent), 1);

        // Random frames: R3 R5 R7 with mixed threshold, padding and CRC mode
        for (int f = 0; f < 40; f++) begin
            set_thr((($urandom % 3) == 0) ? 63 : int'($urandom % 12));
            cfg_pad = $urandom % 2;
            cfg_auto_crc = $urandom % 2;
            pl = int'($urandom % 200);
            need = pl + 16 + (cfg_auto_crc ? 0 : 4);
            w = {$urandom % 65536, 16'(pl)};
            sent = 1'b0;
            do_write(w, 1'b0, sent);
            while (!sent && mcnt < need) do_write($urandom, 1'b0, sent);
            if (!sent) force_send();
        end

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule